// File: doc/BRIEF.md
# Peripheral Clock Control Slice

This block controls the clock enable and the synchronous reset of one peripheral. Software sees it as a single 32-bit register with a write port and a read port. The register picks one of eight single-cycle enable strobes as the source. It slows that source down through a small fractional divider and gates the result before it reaches the peripheral. The same register holds the bit that releases the peripheral's reset. Everything runs on one system clock, and the sources are enable strobes, not separate clocks.

The source select and the divider fields may only change while the gate is off. A write made while the gate is on still updates the gate and reset-release bits, but it leaves the select and divider fields as they were. The divider keeps an accumulator. On each selected source strobe it adds M+1. When the sum reaches N+1 or more, it subtracts N+1 and emits one strobe. The accumulator is cleared whenever the gate is off.

The reset release runs through a sequencer with three states:
- RS_HOLD: the peripheral is in reset. It moves to RS_SYNC when the release bit is 1.
- RS_SYNC: the peripheral is still in reset. It moves to RS_RUN if the release bit is still 1, and back to RS_HOLD if it is not.
- RS_RUN: the peripheral is out of reset. It returns to RS_HOLD when the release bit is cleared.

The reset output is asserted in every state except RS_RUN. It is also asserted whenever the release bit is 0.

Top module: `periph_clk_slice`

## Requirements
- R1: After system reset the register reads 32'h8000_0000, `periph_en` is 0 and `periph_rst` is 1.
- R2: Bit 31 always reads 1, and writes to it are ignored. Bits 29, 27 and 23:4 always read 0. A write of 32'h2FFF_FFF6 while the gate is off reads back as 32'h8700_0006.
- R3: Bit 30 is the gate. A divider strobe reaches `periph_en` only while the stored gate bit is 1, and that includes the cycle right after the edge at which a write clears the gate.
- R4: Bits 26:24 hold the source select S. Only `src_stb[S]` advances the divider, and strobes on the other inputs have no effect.
- R5: Bits 2:0 hold the divide value N. With M=0, every (N+1)-th selected strobe produces a one-cycle `periph_en` pulse in the cycle after that strobe.
- R6: Bit 3 holds the multiplier value M. The accumulator adds M+1 per selected strobe and fires when the sum is N+1 or more, then subtracts N+1. N=2 with M=1 gives the pattern 0,1,1 repeating. When (M+1) is greater than (N+1), the output saturates at one pulse per source strobe.
- R7: Whether a write is locked depends on the gate value stored before that write. While the stored gate is 1, a write leaves bits 26:24, 3 and 2:0 unchanged, and bits 30 and 28 still update.
- R8: Bit 28 is the reset release. Writing 1 lowers `periph_rst` two clock cycles after the write edge.
- R9: Writing 0 to bit 28 raises `periph_rst` in the cycle right after the write edge.
- R10: The divider accumulator is cleared while the gate is off, so counting starts from zero each time the gate is turned back on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| src_stb | input | 8 | Candidate source enable strobes |
| periph_en | output | 1 | Gated, divided peripheral enable |
| periph_rst | output | 1 | Peripheral synchronous reset, active high |

## Verification
Two functions can fall in the same cycle: a register write that turns the gate off, and a selected source strobe that completes the divider count. The bench provokes this by raising `wr_en` and the source strobe in the same cycle, at a point where the accumulator is one strobe away from firing. It judges the result by requiring `periph_en` to stay 0 in the following cycle. A second same-cycle case is a write that turns the gate off and also carries new field values. The read-back must show the old fields, because the lock follows the gate value stored before that write.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    localparam int DATA_W   = 32;
    localparam int PRES_BIT = 31;
    localparam int GATE_BIT = 30;
    localparam int REL_BIT  = 28;
    localparam int SEL_LSB  = 24;
    localparam int DIV_LSB  = 0;

    typedef enum logic [1:0] {
        RS_HOLD = 2'd0,
        RS_SYNC = 2'd1,
        RS_RUN  = 2'd2
    } rst_state_t;
endpackage

// File: rtl/pcc_regs.sv
module pcc_regs
    import pcc_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int DIV_W = 3,
    parameter int MUL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              gate,
    output logic              rel,
    output logic [SEL_W-1:0]  sel,
    output logic [DIV_W-1:0]  div,
    output logic [MUL_W-1:0]  mul,
    output logic [DATA_W-1:0] rd_data
);
    localparam int MUL_LSB = DIV_LSB + DIV_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate <= 1'b0;
            rel  <= 1'b0;
            sel  <= '0;
            div  <= '0;
            mul  <= '0;
        end else if (wr_en) begin
            gate <= wr_data[GATE_BIT];
            rel  <= wr_data[REL_BIT];
            if (!gate) begin
                sel <= wr_data[SEL_LSB +: SEL_W];
                div <= wr_data[DIV_LSB +: DIV_W];
                mul <= wr_data[MUL_LSB +: MUL_W];
            end
        end
    end

    always_comb begin
        rd_data                      = '0;
        rd_data[PRES_BIT]            = 1'b1;
        rd_data[GATE_BIT]            = gate;
        rd_data[REL_BIT]             = rel;
        rd_data[SEL_LSB +: SEL_W]    = sel;
        rd_data[DIV_LSB +: DIV_W]    = div;
        rd_data[MUL_LSB +: MUL_W]    = mul;
    end

    // R7: fields frozen while the stored gate is on
    a_r7_fields_locked: assert property (@(posedge clk) disable iff (!rst_n)
        gate |=> $stable({sel, div, mul}));

    // R7: an unlocked write takes the new select value
    a_r7_unlocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !gate) |=> sel == $past(wr_data[SEL_LSB +: SEL_W]));
endmodule

// File: rtl/pcc_frac_div.sv
module pcc_frac_div #(
    parameter int DIV_W = 3,
    parameter int MUL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             stb_in,
    input  logic [DIV_W-1:0] div,
    input  logic [MUL_W-1:0] mul,
    output logic             stb_out
);
    localparam int ACC_W = ((DIV_W > MUL_W) ? DIV_W : MUL_W) + 2;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] lim;
    logic [ACC_W-1:0] rem;
    logic             hit;

    always_comb begin
        sum = acc + ACC_W'(mul) + ACC_W'(1);
        lim = ACC_W'(div) + ACC_W'(1);
        hit = (sum >= lim);
        rem = sum - lim;
        if (rem > ACC_W'(div)) rem = ACC_W'(div);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            stb_out <= 1'b0;
        end else if (!run) begin
            acc     <= '0;
            stb_out <= 1'b0;
        end else begin
            stb_out <= stb_in && hit;
            if (stb_in) acc <= hit ? rem : sum;
        end
    end

    // R6: accumulator stays below N+1 while running
    a_r6_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= ACC_W'(div));

    // R6: at most one output strobe per accepted input strobe
    a_r6_one_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        stb_out |-> $past(run && stb_in));

    // R10: accumulator empty after an idle cycle
    a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> acc == '0);
endmodule

// File: rtl/pcc_rst_seq.sv
module pcc_rst_seq
    import pcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rel,
    output logic periph_rst
);
    rst_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RS_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RS_HOLD: if (rel) state_nx = RS_SYNC;
            RS_SYNC: state_nx = rel ? RS_RUN : RS_HOLD;
            RS_RUN:  if (!rel) state_nx = RS_HOLD;
            default: state_nx = RS_HOLD;
        endcase
    end

    always_comb begin
        periph_rst = 1'b1;
        unique case (state)
            RS_HOLD: periph_rst = 1'b1;
            RS_SYNC: periph_rst = 1'b1;
            RS_RUN:  periph_rst = !rel;
            default: periph_rst = 1'b1;
        endcase
    end

    // R8: release only after two cycles of the release bit
    a_r8_two_cycle_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_rst) |-> (rel && $past(rel) && $past(rel, 2)));

    // R9: clearing the release bit asserts reset at once
    a_r9_immediate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rel |-> periph_rst);
endmodule

// File: rtl/periph_clk_slice.sv
module periph_clk_slice
    import pcc_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int DIV_W = 3,
    parameter int MUL_W = 1,
    localparam int NSRC = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NSRC-1:0]   src_stb,
    output logic              periph_en,
    output logic              periph_rst
);
    logic             gate;
    logic             rel;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
    logic [MUL_W-1:0] mul;
    logic             chosen;
    logic             div_stb;

    pcc_regs #(.SEL_W(SEL_W), .DIV_W(DIV_W), .MUL_W(MUL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .gate(gate), .rel(rel), .sel(sel), .div(div), .mul(mul),
        .rd_data(rd_data)
    );

    assign chosen = src_stb[sel];

    pcc_frac_div #(.DIV_W(DIV_W), .MUL_W(MUL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(gate), .stb_in(chosen),
        .div(div), .mul(mul), .stb_out(div_stb)
    );

    pcc_rst_seq u_rst (
        .clk(clk), .rst_n(rst_n), .rel(rel), .periph_rst(periph_rst)
    );

    assign periph_en = div_stb && gate;

    // R3: no peripheral enable with the gate off
    a_r3_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> !periph_en);

    // R4: enable pulse traces back to the selected source
    a_r4_selected_source: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en |-> $past(src_stb[sel]));

    // R2: present flag always reads as one
    a_r2_present: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[PRES_BIT]);
endmodule

// File: tb/periph_clk_slice_test.sv
`timescale 1ns/100ps
module periph_clk_slice_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  src_stb = '0;
    logic        periph_en;
    logic        periph_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    periph_clk_slice uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .src_stb(src_stb),
        .periph_en(periph_en), .periph_rst(periph_rst)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input int idx, input logic exp, input string tag);
        @(negedge clk);
        src_stb = 8'(1 << idx);
        @(negedge clk);
        src_stb = '0;
        check(tag, {31'd0, periph_en}, {31'd0, exp});
    endtask

    task automatic t_reset;
        check("R1 read", rd_data, 32'h8000_0000);
        check("R1 en", {31'd0, periph_en}, 32'd0);
        check("R1 rst", {31'd0, periph_rst}, 32'd1);
    endtask

    task automatic t_present;
        write_reg(32'h2FFF_FFF6);
        check("R2 readback", rd_data, 32'h8700_0006);
        write_reg(32'h0000_0000);
        check("R2 cleared", rd_data, 32'h8000_0000);
    endtask

    task automatic t_divide;
        write_reg(32'h4200_0002);
        pulse(2, 1'b0, "R5 s1");
        pulse(5, 1'b0, "R4 other source");
        pulse(2, 1'b0, "R5 s2");
        pulse(2, 1'b1, "R5 s3");
        pulse(2, 1'b0, "R5 s4");
        pulse(0, 1'b0, "R4 other source");
        pulse(2, 1'b0, "R5 s5");
        pulse(2, 1'b1, "R5 s6");
        write_reg(32'h0000_0000);
    endtask

    task automatic t_frac;
        write_reg(32'h4300_000A);
        for (int k = 0; k < 6; k++)
            pulse(3, (k % 3) != 0, "R6 frac 2/3");
        write_reg(32'h0000_0008);
        write_reg(32'h4000_0008);
        for (int k = 0; k < 3; k++)
            pulse(0, 1'b1, "R6 saturate");
    endtask

    task automatic t_lock;
        write_reg(32'h4500_0003);
        check("R7 locked gate on", rd_data, 32'hC000_0008);
        write_reg(32'h1500_0003);
        check("R7 lock by old gate", rd_data, 32'h9000_0008);
        write_reg(32'h0500_0003);
        check("R7 unlocked", rd_data, 32'h8500_0003);
    endtask

    task automatic t_gate_and_clear;
        pulse(5, 1'b0, "R3 gate off");
        pulse(5, 1'b0, "R3 gate off");
        write_reg(32'h0500_0002);
        write_reg(32'h4500_0002);
        pulse(5, 1'b0, "R10 pre");
        pulse(5, 1'b0, "R10 pre");
        write_reg(32'h0500_0002);
        write_reg(32'h4500_0002);
        pulse(5, 1'b0, "R10 fresh 1");
        pulse(5, 1'b0, "R10 fresh 2");
        pulse(5, 1'b1, "R10 fresh 3");
    endtask

    task automatic t_concurrent;
        pulse(5, 1'b0, "R3 setup 1");
        pulse(5, 1'b0, "R3 setup 2");
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h0500_0002; src_stb = 8'h20;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; src_stb = '0;
        check("R3 write vs strobe", {31'd0, periph_en}, 32'd0);
        check("R3 gate cleared", rd_data, 32'h8500_0002);
    endtask

    task automatic t_reset_release;
        write_reg(32'h5500_0002);
        check("R8 cycle 1", {31'd0, periph_rst}, 32'd1);
        @(negedge clk);
        check("R8 cycle 2", {31'd0, periph_rst}, 32'd1);
        @(negedge clk);
        check("R8 released", {31'd0, periph_rst}, 32'd0);
        write_reg(32'h4500_0002);
        check("R9 immediate", {31'd0, periph_rst}, 32'd1);
        check("R9 read", rd_data, 32'hC500_0002);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_present;
        t_divide;
        t_frac;
        t_lock;
        t_gate_and_clear;
        t_concurrent;
        t_reset_release;
        done = 1'b1;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run;
        end
    end
endmodule